// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This peripheral keeps a 16-bit up-count that software reaches as bytes over an 8-bit register bus. The count advances on one of two sources. The first is the internal instruction clock, which is one tick every four system clocks. The second is rising edges on an external clock pin. Ticks from the chosen source pass through a divider that drops three of every four, one of every two, seven of every eight, or none. External edges are normally resolved through a two-flop synchronizer. They can instead be taken straight from the pin to give the lowest latency, which is the asynchronous counting mode.

The counter wraps from 0xFFFF to 0x0000 and sets a sticky overflow flag when it does. A compare unit elsewhere on the chip can clear the count with a one-cycle trigger, if software has routed that trigger to this timer. In paired-access mode, a read of the low byte captures the high byte into a shadow register, so that a later read of the high byte gives a consistent 16-bit value. In the same mode, a write to the high byte only fills the shadow, and a write of the low byte then loads both bytes into the count at once.

Top module: `tmr16_periph`

## Requirements
- R1: After reset, all four registers read 0: control (address 0), count low (address 1), count high (address 2) and status (address 3). The timer is stopped.
- R2: With control bit1 = 0, the count uses the internal source and advances once every 4 clocks times the divide ratio. With ratio 1, the first increment appears 4 clock edges after the edge that captures the control write.
- R3: Control bits 4:3 choose a divide ratio of 1, 2, 4 or 8 (codes 0 to 3). Any write to the control register or to a count byte restarts both the divider and the internal quarter-clock phase.
- R4: With control bit1 = 1 and bit2 = 0, each rising edge on `ext_clk_i` is counted. The increment appears on the third clock edge after the pin rises.
- R5: With control bits 1 and 2 both set, the synchronizer is bypassed and the increment appears on the first clock edge after the pin rises.
- R6: While control bit0 (run) is 0, the count holds its value.
- R7: A wrap from 0xFFFF to 0x0000 sets status bit0. The flag stays set until a status write with bit0 = 0. A write with bit0 = 1 leaves it unchanged. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R8: A `trig_i` pulse clears the count when control bit5 is 1. When bit5 is 0 the pulse has no effect. A count write in the same cycle wins over the trigger.
- R9: With control bit6 = 1, a read strobe at address 1 copies the current high byte into a shadow register. Address 2 then reads the shadow rather than the live count.
- R10: With control bit6 = 1, a write to address 2 fills only the shadow. A write to address 1 loads {shadow, data} into the count in one cycle. With bit6 = 0, both bytes are written directly.
- R11: In the unsynchronized external mode, a count write is held back and replaces the increment at the next counted edge. Until that edge, the count reads its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External count input |
| trig_i | input | 1 | Clear pulse from the compare unit |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (side effect on address 1) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The overflow flag can be set by a wrap and cleared by software in the same cycle. The bench provokes this by loading 0xFFFF, starting the internal source with ratio 1, and timing a status write of 0 so that it is captured on the fourth edge after the start. That is the edge on which the wrap lands. It then expects the flag to read 1 and the count to read 0. The count-write versus trigger priority is also covered by a dedicated bench task.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int DW = 8;
    localparam int CW = 2 * DW;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_LO   = 2'd1;
    localparam logic [1:0] ADR_HI   = 2'd2;
    localparam logic [1:0] ADR_STAT = 2'd3;

    typedef struct packed {
        logic       pair16;    // bit6: paired 16-bit access
        logic       trig_en;   // bit5: route compare trigger
        logic [1:0] div_sel;   // bits4:3: divide 1,2,4,8
        logic       nosync;    // bit2: bypass synchronizer
        logic       ext_src;   // bit1: external source
        logic       run;       // bit0: enable
    } ctrl_t;
endpackage

// File: rtl/tmr16_src.sv
module tmr16_src #(
    parameter int SYNC_STAGES = 2,
    parameter int QDIV        = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_i,
    input  logic ext_sel_i,
    input  logic nosync_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PHW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [PHW-1:0] PH_LAST = PHW'(QDIV - 1);

    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
        logic [PHW-1:0]       ph;
    } st_t;

    st_t st_d, st_q;
    logic sync_edge, raw_edge, int_tick;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[SYNC_STAGES-1:0], ext_i};
        if (clr_i || st_q.ph == PH_LAST) st_d.ph = '0;
        else                             st_d.ph = st_q.ph + PHW'(1);
        sync_edge = st_q.sh[SYNC_STAGES-1] & ~st_q.sh[SYNC_STAGES];
        raw_edge  = ext_i & ~st_q.sh[0];
        int_tick  = (st_q.ph == PH_LAST);
        if (!ext_sel_i)    tick_o = int_tick;
        else if (nosync_i) tick_o = raw_edge;
        else               tick_o = sync_edge;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R2: internal ticks are spaced QDIV clocks apart
    p_int_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ext_sel_i && tick_o && !clr_i) |=> !tick_o || (QDIV == 1));
endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
    parameter int SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clr_i,
    output logic             tick_o
);
    localparam int PW = (2 ** SEL_W) - 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [PW-1:0] last;

    always_comb begin
        last   = PW'((1 << sel_i) - 1);
        st_d   = st_q;
        tick_o = tick_i && (st_q.cnt == last);
        if (clr_i)       st_d.cnt = '0;
        else if (tick_o) st_d.cnt = '0;
        else if (tick_i) st_d.cnt = st_q.cnt + PW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R3: above ratio 1, two output ticks never come back to back
    p_no_double_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (sel_i == '0) || !tick_o);
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
    import tmr16_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          trig_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic          rd_lo_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          pair_i,
    input  logic          defer_i,
    output logic [CW-1:0] cnt_o,
    output logic [DW-1:0] shadow_o,
    output logic          wrap_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] shadow;
        logic          pend;
        logic [CW-1:0] pval;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] base, wval;
    logic          cnt_wr;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        base   = st_q.pend ? st_q.pval : st_q.cnt;
        cnt_wr = wr_lo_i || (wr_hi_i && !pair_i);
        if (wr_lo_i) wval = {(pair_i ? st_q.shadow : base[CW-1:DW]), wdata_i};
        else         wval = {wdata_i, base[DW-1:0]};

        if (pair_i && wr_hi_i)      st_d.shadow = wdata_i;
        else if (pair_i && rd_lo_i) st_d.shadow = st_q.cnt[CW-1:DW];

        if (trig_i) begin
            st_d.cnt  = '0;
            st_d.pend = 1'b0;
        end else if (tick_i) begin
            if (st_q.pend) begin
                st_d.cnt  = st_q.pval;
                st_d.pend = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
                wrap_o   = &st_q.cnt;
            end
        end

        if (cnt_wr) begin
            if (defer_i) begin
                st_d.pend = 1'b1;
                st_d.pval = wval;
            end else begin
                st_d.cnt  = wval;
                st_d.pend = 1'b0;
                wrap_o    = 1'b0;
            end
        end
        cnt_o    = st_q.cnt;
        shadow_o = st_q.shadow;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R6: without a tick, trigger or write the count is frozen
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !trig_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));
    // R8: an unopposed trigger leaves zero behind
    p_trig_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && !wr_lo_i && !wr_hi_i) |=> (cnt_o == '0));
    // R7: a wrap pulse is always followed by a zero count
    p_wrap_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/tmr16_periph.sv
module tmr16_periph
    import tmr16_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ext_clk_i,
    input  logic       trig_i,
    input  logic       bus_wr_i,
    input  logic       bus_rd_i,
    input  logic [1:0] bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       ovf_flag_o
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  flag;
    } st_t;

    st_t st_d, st_q;
    logic wr_ctrl, wr_lo, wr_hi, wr_stat, rd_lo;
    logic src_tick, run_tick, div_tick, restart, wrap, trig_eff;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shadow;

    always_comb begin
        wr_ctrl  = bus_wr_i && (bus_addr_i == ADR_CTRL);
        wr_lo    = bus_wr_i && (bus_addr_i == ADR_LO);
        wr_hi    = bus_wr_i && (bus_addr_i == ADR_HI);
        wr_stat  = bus_wr_i && (bus_addr_i == ADR_STAT);
        rd_lo    = bus_rd_i && (bus_addr_i == ADR_LO);
        restart  = wr_ctrl || wr_lo || wr_hi;
        run_tick = st_q.ctrl.run && src_tick;
        trig_eff = trig_i && st_q.ctrl.trig_en;

        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = ctrl_t'(bus_wdata_i[6:0]);
        if (wrap)                          st_d.flag = 1'b1;
        else if (wr_stat && !bus_wdata_i[0]) st_d.flag = 1'b0;

        case (bus_addr_i)
            ADR_CTRL: bus_rdata_o = {1'b0, st_q.ctrl};
            ADR_LO:   bus_rdata_o = cnt[DW-1:0];
            ADR_HI:   bus_rdata_o = st_q.ctrl.pair16 ? shadow : cnt[CW-1:DW];
            default:  bus_rdata_o = {7'b0, st_q.flag};
        endcase
        ovf_flag_o = st_q.flag;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    tmr16_src #(.SYNC_STAGES(2), .QDIV(4)) u_src (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ext_i     (ext_clk_i),
        .ext_sel_i (st_q.ctrl.ext_src),
        .nosync_i  (st_q.ctrl.nosync),
        .clr_i     (restart),
        .tick_o    (src_tick)
    );

    tmr16_presc #(.SEL_W(2)) u_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (run_tick),
        .sel_i  (st_q.ctrl.div_sel),
        .clr_i  (restart),
        .tick_o (div_tick)
    );

    tmr16_count u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (div_tick),
        .trig_i   (trig_eff),
        .wr_lo_i  (wr_lo),
        .wr_hi_i  (wr_hi),
        .rd_lo_i  (rd_lo),
        .wdata_i  (bus_wdata_i),
        .pair_i   (st_q.ctrl.pair16),
        .defer_i  (st_q.ctrl.ext_src && st_q.ctrl.nosync),
        .cnt_o    (cnt),
        .shadow_o (shadow),
        .wrap_o   (wrap)
    );

    // R7: a wrap always leaves the flag set, even against a clearing write
    p_wrap_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> ovf_flag_o);
    // R7: the flag only drops through a status write with bit0 = 0
    p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_flag_o && !(wr_stat && !bus_wdata_i[0])) |=> ovf_flag_o);
    // R6: a stopped timer produces no divided ticks
    p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.ctrl.run |-> !div_tick);
endmodule

// File: tb/tmr16_periph_tb_top.sv
`timescale 1ns/1ps
module tmr16_periph_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext = 1'b0, trig = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       flag;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr16_periph dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .trig_i(trig),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ovf_flag_o(flag)
    );

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        addr = a; #1;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d: got %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext = 1'b1;
        repeat (4) @(negedge clk);
        ext = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic trig_pulse();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic t_reset();
        chk(2'd0, 8'h00, "R1"); chk(2'd1, 8'h00, "R1");
        chk(2'd2, 8'h00, "R1"); chk(2'd3, 8'h00, "R1");
    endtask

    task automatic t_internal();
        wreg(2'd0, 8'h01);
        chk(2'd0, 8'h01, "R1 ctrl readback");
        repeat (3) @(negedge clk); chk(2'd1, 8'd0, "R2 before first tick");
        @(negedge clk);            chk(2'd1, 8'd1, "R2 first tick");
        repeat (36) @(negedge clk); chk(2'd1, 8'd10, "R2 ratio 1");
        wreg(2'd0, 8'h00);
        repeat (20) @(negedge clk); chk(2'd1, 8'd10, "R6 hold when stopped");
    endtask

    task automatic t_divider();
        wreg(2'd1, 8'h00);
        wreg(2'd0, 8'h19);
        repeat (95) @(negedge clk); chk(2'd1, 8'd2, "R3 ratio 8 early");
        @(negedge clk);             chk(2'd1, 8'd3, "R3 ratio 8");
        wreg(2'd0, 8'h00); wreg(2'd1, 8'h00);
        wreg(2'd0, 8'h09);
        repeat (24) @(negedge clk); chk(2'd1, 8'd3, "R3 ratio 2");
        wreg(2'd0, 8'h00);
    endtask

    task automatic t_ext_sync();
        wreg(2'd1, 8'h00);
        wreg(2'd0, 8'h03);
        repeat (2) @(negedge clk);
        ext = 1'b1;
        @(negedge clk); chk(2'd1, 8'd0, "R4 edge 1");
        @(negedge clk); chk(2'd1, 8'd0, "R4 edge 2");
        @(negedge clk); chk(2'd1, 8'd1, "R4 edge 3");
        ext = 1'b0; repeat (4) @(negedge clk);
        repeat (4) ext_pulse();
        chk(2'd1, 8'd5, "R4 five edges");
        wreg(2'd0, 8'h00); wreg(2'd1, 8'h00);
        wreg(2'd0, 8'h13);
        repeat (12) ext_pulse();
        chk(2'd1, 8'd3, "R3 external ratio 4");
        wreg(2'd0, 8'h00);
    endtask

    task automatic t_ext_async();
        wreg(2'd1, 8'h00);
        wreg(2'd0, 8'h07);
        @(negedge clk); ext = 1'b1;
        @(negedge clk); chk(2'd1, 8'd1, "R5 one-edge latency");
        ext = 1'b0; repeat (4) @(negedge clk);
        wreg(2'd1, 8'h55);
        repeat (3) @(negedge clk); chk(2'd1, 8'd1, "R11 write held back");
        ext_pulse(); chk(2'd1, 8'h55, "R11 write lands on edge");
        ext_pulse(); chk(2'd1, 8'h56, "R11 counting resumes");
        wreg(2'd0, 8'h00);
    endtask

    task automatic t_overflow();
        wreg(2'd2, 8'hFF); wreg(2'd1, 8'hFE);
        wreg(2'd0, 8'h01);
        repeat (8) @(negedge clk);
        chk(2'd1, 8'h00, "R7 wrap low"); chk(2'd2, 8'h00, "R7 wrap high");
        chk(2'd3, 8'h01, "R7 flag set");
        wreg(2'd0, 8'h00);
        repeat (10) @(negedge clk); chk(2'd3, 8'h01, "R7 sticky");
        wreg(2'd3, 8'h01); chk(2'd3, 8'h01, "R7 write of 1 ignored");
        wreg(2'd3, 8'h00); chk(2'd3, 8'h00, "R7 cleared");
        wreg(2'd2, 8'hFF); wreg(2'd1, 8'hFF);
        wreg(2'd0, 8'h01);
        repeat (2) @(negedge clk);
        wreg(2'd3, 8'h00);
        chk(2'd3, 8'h01, "R7 set wins over clear");
        chk(2'd1, 8'h00, "R7 count wrapped");
        wreg(2'd0, 8'h00);
        wreg(2'd3, 8'h00);
    endtask

    task automatic t_trigger();
        wreg(2'd0, 8'h20); wreg(2'd1, 8'h33);
        trig_pulse(); chk(2'd1, 8'h00, "R8 routed trigger clears");
        wreg(2'd0, 8'h00); wreg(2'd1, 8'h44);
        trig_pulse(); chk(2'd1, 8'h44, "R8 unrouted trigger ignored");
        wreg(2'd0, 8'h20);
        @(negedge clk); trig = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 8'h66;
        @(negedge clk); trig = 1'b0; wr = 1'b0;
        chk(2'd1, 8'h66, "R8 write beats trigger");
        wreg(2'd0, 8'h00);
    endtask

    task automatic t_pair();
        wreg(2'd2, 8'h12); wreg(2'd1, 8'h34);
        wreg(2'd0, 8'h60);
        @(negedge clk); addr = 2'd1; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        trig_pulse();
        chk(2'd2, 8'h12, "R9 shadow holds high byte");
        chk(2'd1, 8'h00, "R9 live low byte");
        wreg(2'd0, 8'h40); wreg(2'd2, 8'hAB);
        wreg(2'd0, 8'h00);
        chk(2'd2, 8'h00, "R10 high write only to shadow");
        wreg(2'd0, 8'h40); wreg(2'd1, 8'hCD);
        wreg(2'd0, 8'h00);
        chk(2'd2, 8'hAB, "R10 paired load high");
        chk(2'd1, 8'hCD, "R10 paired load low");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_internal();
        t_divider();
        t_ext_sync();
        t_ext_async();
        t_overflow();
        t_trigger();
        t_pair();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule